// File: doc/BRIEF.md
# Four-Lane Swizzle Move Unit

This block rearranges a short vector of four 32-bit elements carried in a pair of 64-bit words. A 12-bit immediate holds one 3-bit selector per destination lane. Each selector either copies one of the four source lanes, inserts a constant zero or one, leaves the destination lane as it was, or marks where the destination subvector ends. The old destination contents come in beside the source so that lanes that are skipped or lie past the end marker keep their value.

A float/int flag picks the encoding of the constant one. A saturation flag makes the integer "one" code insert the all-ones maximum instead. The result is registered. It appears with a valid strobe one cycle after the input strobe, together with the effective destination subvector length. All source lanes are taken from the inputs of the strobe cycle, so the source pair and the destination pair may be the same registers.

Top module: `swz_move4`

## Requirements
- R1: Destination lane i (0 to 3) is controlled by imm bits [3i+2:3i]. Lanes 0 and 1 are bits [31:0] and [63:32] of the low word, and lanes 2 and 3 are the same bits of the high word, for source, old destination and result alike.
- R2: Selector codes 3'b100, 3'b101, 3'b110 and 3'b111 copy source lane 0 (X), 1 (Y), 2 (Z) and 3 (W) into the destination lane.
- R3: Selector code 3'b000 leaves the destination lane equal to the old destination lane.
- R4: Selector code 3'b001 ends the subvector. That lane and every later lane keep their old value. dst_len equals the index of the first 3'b001 lane, or 4 when no selector is 3'b001.
- R5: Selector code 3'b010 writes 32'h0000_0000 in both integer and float mode.
- R6: Selector code 3'b011 writes 32'h0000_0001 when is_float is 0 and 32'h3F80_0000 when is_float is 1, provided saturation is off.
- R7: With sat_en high in integer mode, code 3'b011 writes 32'hFFFF_FFFF. In float mode it still writes 32'h3F80_0000, and code 3'b010 still writes zero.
- R8: out_valid is high in exactly the cycle after a cycle with in_valid high. dst_lo, dst_hi and dst_len change only in that cycle and hold otherwise.
- R9: When old_lo/old_hi equal src_lo/src_hi (the same register pair), every copied lane takes the source value presented with the strobe, so a lane swap returns both original values exchanged.
- R10: After reset, out_valid is 0 and dst_lo, dst_hi and dst_len are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and immediate are valid this cycle |
| src_lo | input | 64 | Source lanes 0 and 1 |
| src_hi | input | 64 | Source lanes 2 and 3 |
| old_lo | input | 64 | Previous destination lanes 0 and 1 |
| old_hi | input | 64 | Previous destination lanes 2 and 3 |
| imm | input | 12 | Four 3-bit lane selectors |
| is_float | input | 1 | Constant one is 1.0 in single precision |
| sat_en | input | 1 | Integer constant one becomes the maximum value |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| dst_lo | output | 64 | Result lanes 0 and 1 |
| dst_hi | output | 64 | Result lanes 2 and 3 |
| dst_len | output | 3 | Effective destination subvector length, 0 to 4 |

## Verification
On every cycle the assertions check the one-cycle strobe timing and the holding of results between strobes. For lane 0 they also check the skip, end-marker and source-copy codes against the inputs of the previous cycle, and they check that the reported length never exceeds four. Only the bench scenarios show the constants in each mode and under saturation, end markers at every position, patterns that reverse or duplicate lanes, and the swap with source and destination the same pair. A reference model checks these against random immediates.

// File: rtl/swz_pkg.sv
package swz_pkg;
   // Selector code values; codes at or above the source base select lanes.
   localparam int unsigned SZC_SKIP = 0;
   localparam int unsigned SZC_END  = 1;
   localparam int unsigned SZC_ZERO = 2;
   localparam int unsigned SZC_ONE  = 3;
   localparam int unsigned SZC_NUM_SPECIAL = 4;

   localparam logic [31:0] FP32_ONE = 32'h3F80_0000;
endpackage

// File: rtl/swz_len_scan.sv
module swz_len_scan #(
   parameter int LANES = 4,
   parameter int SEL_W = 3,
   localparam int LEN_W = $clog2(LANES + 1)
) (
   input  logic [LANES*SEL_W-1:0] imm,
   output logic [LEN_W-1:0]       sub_len,
   output logic [LANES-1:0]       lane_wr
);
   import swz_pkg::*;

   logic found;

   always_comb begin
      found   = 1'b0;
      sub_len = LEN_W'(LANES);
      lane_wr = '0;
      for (int i = 0; i < LANES; i++) begin
         if (!found && imm[i*SEL_W +: SEL_W] == SEL_W'(SZC_END)) begin
            found   = 1'b1;
            sub_len = LEN_W'(i);
         end
         lane_wr[i] = !found;
      end
   end
endmodule

// File: rtl/swz_lane_sel.sv
module swz_lane_sel #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   parameter int SEL_W  = 3,
   parameter bit SAT_OPT = 1'b1,
   parameter logic [LANE_W-1:0] FP_ONE  = 32'h3F80_0000,
   parameter logic [LANE_W-1:0] INT_ONE = 1,
   parameter logic [LANE_W-1:0] INT_MAX = '1
) (
   input  logic [SEL_W-1:0]        code,
   input  logic [LANES*LANE_W-1:0] src_all,
   input  logic [LANE_W-1:0]       old_val,
   input  logic                    wr_en,
   input  logic                    is_float,
   input  logic                    sat_en,
   output logic [LANE_W-1:0]       lane_out
);
   import swz_pkg::*;

   localparam int SRC_BASE = (1 << SEL_W) - LANES;

   logic [LANES-1:0]  hit;
   logic [LANE_W-1:0] pick;
   logic [LANE_W-1:0] one_val;
   logic              sat_act;

   for (genvar s = 0; s < LANES; s++) begin : g_hit
      assign hit[s] = (code == SEL_W'(SRC_BASE + s));
   end

   always_comb begin
      pick = '0;
      for (int s = 0; s < LANES; s++) begin
         pick = pick | (src_all[s*LANE_W +: LANE_W] & {LANE_W{hit[s]}});
      end
   end

   if (SAT_OPT) begin : g_sat
      assign sat_act = sat_en;
   end else begin : g_nosat
      assign sat_act = 1'b0 & sat_en;
   end

   assign one_val = is_float ? FP_ONE : (sat_act ? INT_MAX : INT_ONE);

   always_comb begin
      if (!wr_en || code == SEL_W'(SZC_SKIP) || code == SEL_W'(SZC_END)) begin
         lane_out = old_val;
      end else if (code == SEL_W'(SZC_ZERO)) begin
         lane_out = '0;
      end else if (code == SEL_W'(SZC_ONE)) begin
         lane_out = one_val;
      end else begin
         lane_out = pick;
      end
   end
endmodule

// File: rtl/swz_move4.sv
module swz_move4 #(
   parameter int LANE_W  = 32,
   parameter int LANES   = 4,
   parameter int SEL_W   = 3,
   parameter bit SAT_OPT = 1'b1,
   localparam int WORD_W = LANES * LANE_W / 2,
   localparam int IMM_W  = LANES * SEL_W,
   localparam int LEN_W  = $clog2(LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] src_lo,
   input  logic [WORD_W-1:0] src_hi,
   input  logic [WORD_W-1:0] old_lo,
   input  logic [WORD_W-1:0] old_hi,
   input  logic [IMM_W-1:0]  imm,
   input  logic              is_float,
   input  logic              sat_en,
   output logic              out_valid,
   output logic [WORD_W-1:0] dst_lo,
   output logic [WORD_W-1:0] dst_hi,
   output logic [LEN_W-1:0]  dst_len
);
   import swz_pkg::*;

   initial begin
      if ((1 << SEL_W) != LANES + int'(SZC_NUM_SPECIAL))
         $error("swz_move4: selector width must leave exactly four special codes");
      if (LANES % 2 != 0)
         $error("swz_move4: lane count must split evenly over two words");
      if (LANE_W != 32)
         $error("swz_move4: constant encodings assume 32-bit lanes");
   end

   logic [2*WORD_W-1:0] src_all, old_all, nxt_all, dst_all;
   logic [LANES-1:0]    lane_wr;
   logic [LEN_W-1:0]    sub_len;

   assign src_all = {src_hi, src_lo};
   assign old_all = {old_hi, old_lo};

   swz_len_scan #(.LANES(LANES), .SEL_W(SEL_W)) u_len (
      .imm     (imm),
      .sub_len (sub_len),
      .lane_wr (lane_wr)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      swz_lane_sel #(
         .LANE_W  (LANE_W),
         .LANES   (LANES),
         .SEL_W   (SEL_W),
         .SAT_OPT (SAT_OPT),
         .FP_ONE  (LANE_W'(FP32_ONE)),
         .INT_ONE (LANE_W'(1)),
         .INT_MAX ({LANE_W{1'b1}})
      ) u_sel (
         .code     (imm[i*SEL_W +: SEL_W]),
         .src_all  (src_all),
         .old_val  (old_all[i*LANE_W +: LANE_W]),
         .wr_en    (lane_wr[i]),
         .is_float (is_float),
         .sat_en   (sat_en),
         .lane_out (nxt_all[i*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         dst_all   <= '0;
         dst_len   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            dst_all <= nxt_all;
            dst_len <= sub_len;
         end
      end
   end

   assign dst_lo = dst_all[WORD_W-1:0];
   assign dst_hi = dst_all[2*WORD_W-1:WORD_W];
endmodule

// File: rtl/swz_move4_chk.sv
module swz_move4_chk #(
   parameter int LANE_W = 32,
   parameter int LANES  = 4,
   parameter int SEL_W  = 3,
   localparam int WORD_W = LANES * LANE_W / 2,
   localparam int IMM_W  = LANES * SEL_W,
   localparam int LEN_W  = $clog2(LANES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [WORD_W-1:0] src_lo,
   input logic [WORD_W-1:0] src_hi,
   input logic [WORD_W-1:0] old_lo,
   input logic [WORD_W-1:0] old_hi,
   input logic [IMM_W-1:0]  imm,
   input logic              is_float,
   input logic              sat_en,
   input logic              out_valid,
   input logic [WORD_W-1:0] dst_lo,
   input logic [WORD_W-1:0] dst_hi,
   input logic [LEN_W-1:0]  dst_len
);
   logic [2*WORD_W-1:0] src_all;
   logic [LANE_W-1:0]   lane0_pick;
   logic                lane0_copy;

   assign src_all    = {src_hi, src_lo};
   assign lane0_copy = imm[SEL_W-1];
   assign lane0_pick = src_all[imm[SEL_W-2:0]*LANE_W +: LANE_W];

   AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid); // R8
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R8
   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(dst_lo) && $stable(dst_hi) && $stable(dst_len))); // R8
   AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(dst_len) <= LANES)); // R4
   AST_SKIP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && imm[SEL_W-1:0] == '0) |=> dst_lo[LANE_W-1:0] == $past(old_lo[LANE_W-1:0])); // R3
   AST_MARK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && imm[SEL_W-1:0] == SEL_W'(1)) |=>
         (dst_len == '0 && dst_lo == $past(old_lo) && dst_hi == $past(old_hi))); // R4
   AST_COPY_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && lane0_copy) |=> dst_lo[LANE_W-1:0] == $past(lane0_pick)); // R2
endmodule

bind swz_move4 swz_move4_chk #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/swz_move4_test.sv
`timescale 1ns/1ps
module swz_move4_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] src_lo = '0, src_hi = '0, old_lo = '0, old_hi = '0;
   logic [11:0] imm = '0;
   logic        is_float = 1'b0, sat_en = 1'b0;
   logic        out_valid;
   logic [63:0] dst_lo, dst_hi;
   logic [2:0]  dst_len;

   int total = 0;
   int bad = 0;

   // reference state
   logic [31:0] e_lane[4];
   int          e_len = 0;
   logic        e_vld = 1'b0;

   always #2 clk = ~clk;

   swz_move4 uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .src_lo(src_lo), .src_hi(src_hi), .old_lo(old_lo), .old_hi(old_hi),
      .imm(imm), .is_float(is_float), .sat_en(sat_en),
      .out_valid(out_valid), .dst_lo(dst_lo), .dst_hi(dst_hi), .dst_len(dst_len)
   );

   function automatic logic [31:0] lane_of(logic [63:0] lo, logic [63:0] hi, int k);
      logic [127:0] all = {hi, lo};
      return all[k*32 +: 32];
   endfunction

   // behavioural model of one strobe
   task automatic model();
      logic [31:0] s[4];
      logic [31:0] o[4];
      bit ended = 0;
      int len = 4;
      for (int k = 0; k < 4; k++) begin
         s[k] = lane_of(src_lo, src_hi, k);
         o[k] = lane_of(old_lo, old_hi, k);
      end
      for (int k = 0; k < 4; k++) begin
         int c = int'(imm[k*3 +: 3]);
         if (!ended && c == 1) begin ended = 1; len = k; end
         if (ended || c == 0) e_lane[k] = o[k];
         else if (c == 2) e_lane[k] = 32'h0;
         else if (c == 3) e_lane[k] = is_float ? 32'h3F80_0000 : (sat_en ? 32'hFFFF_FFFF : 32'h1);
         else e_lane[k] = s[c - 4];
      end
      e_len = len;
   endtask

   task automatic check(string tag);
      logic [127:0] exp_all = {e_lane[3], e_lane[2], e_lane[1], e_lane[0]};
      total++;
      if (out_valid !== e_vld || {dst_hi, dst_lo} !== exp_all || int'(dst_len) != e_len) begin
         bad++;
         $display("FAIL %s: got v=%0b data=%h len=%0d, expected v=%0b data=%h len=%0d",
                  tag, out_valid, {dst_hi, dst_lo}, dst_len, e_vld, exp_all, e_len);
      end
   endtask

   // one clock: inputs set at negedge, checked at the next negedge
   task automatic cyc(string tag, bit v, logic [11:0] im, logic [63:0] sl, logic [63:0] sh,
                      logic [63:0] ol, logic [63:0] oh, bit fl, bit st);
      in_valid = v; imm = im; src_lo = sl; src_hi = sh; old_lo = ol; old_hi = oh;
      is_float = fl; sat_en = st;
      if (v) model();
      e_vld = v;
      @(posedge clk);
      @(negedge clk);
      check(tag);
   endtask

   function automatic logic [11:0] sel(int l3, int l2, int l1, int l0);
      return {3'(l3), 3'(l2), 3'(l1), 3'(l0)};
   endfunction

   localparam logic [63:0] SL = 64'h2222_2222_1111_1111;
   localparam logic [63:0] SH = 64'h4444_4444_3333_3333;
   localparam logic [63:0] OL = 64'hBBBB_BBBB_AAAA_AAAA;
   localparam logic [63:0] OH = 64'hDDDD_DDDD_CCCC_CCCC;

   initial begin
      #(4 * 200000);
      bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) e_lane[k] = '0;
      repeat (3) @(negedge clk);
      total++;  // R10 reset state
      if (out_valid !== 1'b0 || dst_lo !== '0 || dst_hi !== '0 || dst_len !== '0) begin
         bad++;
         $display("FAIL R10: got v=%0b lo=%h hi=%h len=%0d, expected all zero",
                  out_valid, dst_lo, dst_hi, dst_len);
      end
      rst_n = 1'b1;
      @(negedge clk);
      cyc("R10 idle after reset", 0, '0, SL, SH, OL, OH, 0, 0);
      cyc("R1 identity XYZW", 1, sel(7, 6, 5, 4), SL, SH, OL, OH, 0, 0);
      cyc("R2 reverse WZYX", 1, sel(4, 5, 6, 7), SL, SH, OL, OH, 0, 0);
      cyc("R2 duplicate YYXX", 1, sel(4, 4, 5, 5), SL, SH, OL, OH, 0, 0);
      cyc("R3 skip pattern W.Y.", 1, sel(0, 5, 0, 7), SL, SH, OL, OH, 0, 0);
      cyc("R8 hold while idle", 0, sel(7, 7, 7, 7), SH, SL, OH, OL, 0, 0);
      cyc("R8 hold second idle", 0, '0, '0, '0, '0, '0, 1, 1);
      cyc("R4 marker at lane 2", 1, sel(6, 1, 6, 7), SL, SH, OL, OH, 0, 0);
      cyc("R4 marker at lane 0", 1, sel(4, 5, 6, 1), SL, SH, OL, OH, 0, 0);
      cyc("R4 marker at lane 3", 1, sel(1, 4, 4, 4), SL, SH, OL, OH, 0, 0);
      cyc("R4 later codes after marker", 1, sel(2, 3, 1, 5), SL, SH, OL, OH, 0, 0);
      cyc("R5 R6 integer constants", 1, sel(3, 2, 3, 2), SL, SH, OL, OH, 0, 0);
      cyc("R5 R6 float constants", 1, sel(2, 3, 2, 3), SL, SH, OL, OH, 1, 0);
      cyc("R7 saturated integer", 1, sel(3, 2, 3, 4), SL, SH, OL, OH, 0, 1);
      cyc("R7 saturated float", 1, sel(3, 2, 3, 4), SL, SH, OL, OH, 1, 1);
      cyc("R9 overlap swap XY ZW", 1, sel(6, 7, 4, 5), SL, SH, SL, SH, 0, 0);
      cyc("R9 overlap rotate", 1, sel(4, 7, 6, 5), SL, SH, SL, SH, 0, 0);
      cyc("R8 back to idle", 0, '0, '0, '0, '0, '0, 0, 0);
      for (int n = 0; n < 400; n++) begin
         logic [63:0] a = {$urandom(), $urandom()};
         logic [63:0] b = {$urandom(), $urandom()};
         logic [63:0] c = {$urandom(), $urandom()};
         logic [63:0] d = {$urandom(), $urandom()};
         bit ovl = ($urandom() % 3) == 0;
         bit v = ($urandom() % 4) != 0;
         cyc("R1 random", v, 12'($urandom()), a, b, ovl ? a : c, ovl ? b : d,
             1'($urandom()), 1'($urandom()));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule